// File: doc/BRIEF.md
# Polling Receiver Wake-Up Controller

This block duty-cycles the signal path of a low-power radio receiver. While nothing is being received it loops through three phases: a long idle phase with the signal path off, a fixed settling phase after the path is switched on, and a short qualification phase. In the qualification phase the block times the edges of the demodulated data stream. If the edge timing matches a transmitter at the selected data-rate range, the block moves into a receiving state and stays there. If the timing does not match, the block goes back to idle.

In the receiving state the demodulated data is forwarded to the data output. An external OFF command returns the block to the idle phase. The idle length is the product of a 5-bit sleep word, an extension factor and a fixed prescale count. The qualification limits come from a per-range table of half-bit durations. The number of intervals that must qualify is programmable. All configuration arrives on static inputs.

Top module: `rx_poll_wake`

## Requirements
- R1: After reset the state code is 0 (Sleep). States only advance in the order Sleep (0) → Start-up (1) → Bit-check (2), and Bit-check leaves only to Receiving (3) or Sleep.
- R2: `active_o` and `rf_en_o` are low in Sleep and high in every other state.
- R3: Sleep lasts `sleep_word_i × ext × PRESCALE` clocks, where an extension input of 0 counts as 1. A sleep word of 0 gives one clock in Sleep.
- R4: Start-up lasts exactly `STARTUP_CYC` clocks (default 1024).
- R5: For baud select s, the half-bit length is h = `HB_UNIT` × 2^(3−s). An edge interval (clocks from one data edge to the next) is accepted when h − h/4 ≤ interval ≤ 2h + h/4, using integer division.
- R6: In Bit-check the first data edge starts the timing. Once `check_bits_i` consecutive intervals have been accepted, the block enters Receiving. A count of 0 acts as 1.
- R7: An interval below the minimum or above the maximum sends the block from Bit-check to Sleep.
- R8: If no edge arrives within the maximum interval, counted from entry or from the last edge, the block returns to Sleep. With no edges at all, Bit-check lasts exactly the maximum interval in clocks.
- R9: In Receiving, `data_o` equals `data_i` as it was one clock earlier.
- R10: `data_o` is low in Sleep, Start-up and Bit-check, whatever `data_i` does.
- R11: `off_i` high in Receiving moves the block to Sleep on the next clock. In the other states `off_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_i | input | 1 | Demodulated data bit |
| sleep_word_i | input | WW (5) | Sleep length word |
| sleep_ext_i | input | XW (3) | Sleep extension factor, 0 treated as 1 |
| baud_sel_i | input | 2 | Baud-range select |
| check_bits_i | input | NW (4) | Number of intervals to qualify |
| off_i | input | 1 | OFF command |
| rf_en_o | output | 1 | Signal-path enable |
| active_o | output | 1 | Active indicator |
| data_o | output | 1 | Gated data output |
| state_o | output | 2 | State code: 0 Sleep, 1 Start-up, 2 Bit-check, 3 Receiving |

## Verification
The hardest case to reach is a qualification run that fails partway through, after some intervals have already been accepted. This needs edges placed cycle-exactly relative to the moment Bit-check is entered. The bench waits for the state code to reach 2 and toggles the data at once to start the timing. It then spaces the following toggles by chosen clock counts, mixing legal half-bit and full-bit intervals with one interval just below the minimum or just above the maximum at a random position. Randomised runs also vary the baud range and the qualify count, and the bench predicts Receiving or Sleep for each run. Timeout is checked by measuring the exact length of an edge-free Bit-check phase.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_START = 2'd1,
    ST_CHECK = 2'd2,
    ST_RECV  = 2'd3
  } rxw_state_e;

endpackage

// File: rtl/rxw_edge_det.sv
module rxw_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic edge_o
);

  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o    = s1_q;
  assign edge_o = s1_q ^ s2_q;

endmodule

// File: rtl/rxw_sleep_timer.sv
module rxw_sleep_timer #(
  parameter int PRESCALE = 1024,
  parameter int WW       = 5,
  parameter int XW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [WW-1:0] word_i,
  input  logic [XW-1:0] ext_i,
  output logic          done_o
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [XW-1:0] xc_q, xc_d;
  logic [WW-1:0] wc_q, wc_d;
  logic [XW-1:0] ext_eff;
  logic          pre_last, x_last, w_last;

  assign ext_eff  = (ext_i == '0) ? XW'(1) : ext_i;
  assign pre_last = (pre_q >= PW'(PRESCALE - 1));
  assign x_last   = (xc_q >= ext_eff - XW'(1));
  assign w_last   = (word_i == '0) || (wc_q >= word_i - WW'(1));
  assign done_o   = run_i && ((word_i == '0) || (pre_last && x_last && w_last));

  always_comb begin
    pre_d = pre_q;
    xc_d  = xc_q;
    wc_d  = wc_q;
    if (!run_i || done_o) begin
      pre_d = '0;
      xc_d  = '0;
      wc_d  = '0;
    end else begin
      pre_d = pre_last ? '0 : pre_q + PW'(1);
      if (pre_last) begin
        xc_d = x_last ? '0 : xc_q + XW'(1);
        if (x_last) wc_d = wc_q + WW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      xc_q  <= '0;
      wc_q  <= '0;
    end else begin
      pre_q <= pre_d;
      xc_q  <= xc_d;
      wc_q  <= wc_d;
    end
  end

  // R3
  prescale_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !done_o && !pre_last) |=> (pre_q == $past(pre_q) + PW'(1)));

  // R3
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0 && xc_q == '0 && wc_q == '0));

endmodule

// File: rtl/rxw_bit_check.sv
module rxw_bit_check #(
  parameter int CW = 12,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          edge_i,
  input  logic [CW-1:0] lim_min_i,
  input  logic [CW-1:0] lim_max_i,
  input  logic [NW-1:0] need_i,
  output logic          pass_o,
  output logic          fail_o
);

  logic [CW-1:0] cnt_q, cnt_d, ivl;
  logic          armed_q, armed_d;
  logic [NW-1:0] ok_q, ok_d;
  logic [NW-1:0] need_eff;
  logic          bad, good, tmo;

  assign ivl      = cnt_q + CW'(1);
  assign need_eff = (need_i == '0) ? NW'(1) : need_i;
  assign bad      = armed_q && edge_i && ((ivl < lim_min_i) || (ivl > lim_max_i));
  assign good     = armed_q && edge_i && !bad;
  assign tmo      = !edge_i && (ivl >= lim_max_i);
  assign pass_o   = en_i && good && (({1'b0, ok_q} + (NW+1)'(1)) >= {1'b0, need_eff});
  assign fail_o   = en_i && (bad || tmo);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    ok_d    = ok_q;
    if (!en_i) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      ok_d    = '0;
    end else if (edge_i) begin
      cnt_d   = '0;
      armed_d = 1'b1;
      if (good && ok_q != '1) ok_d = ok_q + NW'(1);
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ok_q    <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      ok_q    <= ok_d;
    end
  end

  // R6
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> !fail_o);

  // R8
  interval_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !edge_i && !fail_o && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R6
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !armed_q) |-> !pass_o);

endmodule

// File: rtl/rx_poll_wake.sv
module rx_poll_wake #(
  parameter int PRESCALE    = 1024,
  parameter int STARTUP_CYC = 1024,
  parameter int HB_UNIT     = 16,
  parameter int CW          = 12,
  parameter int WW          = 5,
  parameter int XW          = 3,
  parameter int NW          = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_i,
  input  logic [WW-1:0] sleep_word_i,
  input  logic [XW-1:0] sleep_ext_i,
  input  logic [1:0]    baud_sel_i,
  input  logic [NW-1:0] check_bits_i,
  input  logic          off_i,
  output logic          rf_en_o,
  output logic          active_o,
  output logic          data_o,
  output logic [1:0]    state_o
);

  import rxw_pkg::*;

  localparam int NRANGE = 4;
  localparam int SW     = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;

  rxw_state_e st_q, st_d;
  logic [SW-1:0] su_q, su_d;
  logic          su_last;
  logic          sleep_done, chk_pass, chk_fail;
  logic          d_sync, d_edge;

  logic [CW-1:0] half_t [NRANGE];
  logic [CW-1:0] min_t  [NRANGE];
  logic [CW-1:0] max_t  [NRANGE];

  for (genvar g = 0; g < NRANGE; g++) begin : g_rng
    assign half_t[g] = CW'(HB_UNIT << (NRANGE - 1 - g));
    assign min_t[g]  = half_t[g] - (half_t[g] >> 2);
    assign max_t[g]  = (half_t[g] << 1) + (half_t[g] >> 2);
  end

  rxw_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (data_i),
    .q_o    (d_sync),
    .edge_o (d_edge)
  );

  rxw_sleep_timer #(
    .PRESCALE (PRESCALE),
    .WW       (WW),
    .XW       (XW)
  ) u_sleep (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (st_q == ST_SLEEP),
    .word_i (sleep_word_i),
    .ext_i  (sleep_ext_i),
    .done_o (sleep_done)
  );

  rxw_bit_check #(
    .CW (CW),
    .NW (NW)
  ) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (st_q == ST_CHECK),
    .edge_i    (d_edge),
    .lim_min_i (min_t[baud_sel_i]),
    .lim_max_i (max_t[baud_sel_i]),
    .need_i    (check_bits_i),
    .pass_o    (chk_pass),
    .fail_o    (chk_fail)
  );

  assign su_last = (su_q == SW'(STARTUP_CYC - 1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_SLEEP: if (sleep_done) st_d = ST_START;
      ST_START: if (su_last)    st_d = ST_CHECK;
      ST_CHECK: begin
        if (chk_pass)      st_d = ST_RECV;
        else if (chk_fail) st_d = ST_SLEEP;
      end
      ST_RECV:  if (off_i)      st_d = ST_SLEEP;
      default:                  st_d = ST_SLEEP;
    endcase
  end

  always_comb begin
    su_d = '0;
    if (st_q == ST_START && !su_last) su_d = su_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_SLEEP;
      su_q <= '0;
    end else begin
      st_q <= st_d;
      su_q <= su_d;
    end
  end

  assign state_o  = st_q;
  assign active_o = (st_q != ST_SLEEP);
  assign rf_en_o  = (st_q != ST_SLEEP);
  assign data_o   = (st_q == ST_RECV) && d_sync;

  // R1
  sleep_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SLEEP) |=> (st_q inside {ST_SLEEP, ST_START}));

  // R1
  start_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START) |=> (st_q inside {ST_START, ST_CHECK}));

  // R1
  recv_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RECV) && ($past(st_q) != ST_RECV)) |-> ($past(st_q) == ST_CHECK));

  // R4
  startup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && $past(st_q) == ST_START) |-> ($past(su_q) == SW'(STARTUP_CYC - 1)));

  // R11
  off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RECV && off_i) |=> (st_q == ST_SLEEP));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (!rf_en_o && !data_o));

  // R7
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && chk_fail) |=> (st_q == ST_SLEEP));

endmodule

// File: tb/rx_poll_wake_tb.sv
module rx_poll_wake_tb;

  localparam int PS = 8;
  localparam int SU = 20;
  localparam int HB = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       data;
  logic [4:0] word;
  logic [2:0] ext;
  logic [1:0] sel;
  logic [3:0] bits;
  logic       off;
  logic       rf_en, active, dout;
  logic [1:0] state;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rx_poll_wake #(
    .PRESCALE    (PS),
    .STARTUP_CYC (SU),
    .HB_UNIT     (HB)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_i       (data),
    .sleep_word_i (word),
    .sleep_ext_i  (ext),
    .baud_sel_i   (sel),
    .check_bits_i (bits),
    .off_i        (off),
    .rf_en_o      (rf_en),
    .active_o     (active),
    .data_o       (dout),
    .state_o      (state)
  );

  function automatic int half_of(int r);
    return HB << (3 - r);
  endfunction
  function automatic int lmin(int r);
    return half_of(r) - half_of(r) / 4;
  endfunction
  function automatic int lmax(int r);
    return 2 * half_of(r) + half_of(r) / 4;
  endfunction
  function automatic int exp_sleep(int w, int x);
    if (w == 0) return 1;
    return w * ((x == 0) ? 1 : x) * PS;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_state(int s);
    int n = 0;
    while (int'(state) != s && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (int'(state) != s) check(1'b0, "R1 wait for state", int'(state), s);
  endtask

  task automatic count_run(int s, output int n);
    n = 0;
    while (int'(state) == s && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic off_pulse();
    off = 1'b1;
    @(negedge clk);
    off = 1'b0;
    check(state == 2'd0, "R11 off leaves receiving", int'(state), 0);
  endtask

  task automatic run_trial(int r, int n, int bad_at, int bad_len);
    int ne;
    int d;
    bit ok = 1'b1;
    sel  = 2'(r);
    bits = 4'(n);
    wait_state(2);
    check(dout == 1'b0, "R10 data low in bit-check", int'(dout), 0);
    data = ~data;
    ne = (n == 0) ? 1 : n;
    for (int i = 0; i < ne; i++) begin
      if (i == bad_at) d = bad_len;
      else d = ($urandom % 2) ? half_of(r) : 2 * half_of(r);
      repeat (d) @(negedge clk);
      if (state != 2'd3) check(dout == 1'b0, "R10 data low before receiving", int'(dout), 0);
      data = ~data;
      if (i == bad_at) begin
        ok = 1'b0;
        break;
      end
    end
    repeat (3) @(negedge clk);
    if (ok) begin
      check(state == 2'd3, "R6 qualify to receiving", int'(state), 3);
      if (state == 2'd3) off_pulse();
    end else begin
      check(state == 2'd0, "R7 rejected interval to sleep", int'(state), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int v;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    data  = 1'b0;
    word  = 5'd1;
    ext   = 3'd1;
    sel   = 2'd3;
    bits  = 4'd3;
    off   = 1'b0;
    repeat (3) @(negedge clk);
    check(state == 2'd0, "R1 reset state", int'(state), 0);
    check(active == 1'b0 && rf_en == 1'b0, "R2 idle outputs in reset", int'(active), 0);
    check(dout == 1'b0, "R10 data low in reset", int'(dout), 0);
    rst_n = 1'b1;

    // R4 start-up length and R2 outputs during start-up
    wait_state(1);
    check(active == 1'b1 && rf_en == 1'b1, "R2 outputs high in start-up", int'(active), 1);
    count_run(1, n);
    check(n == SU, "R4 start-up length", n, SU);

    // R6 directed pass in range 3
    run_trial(3, 3, -1, 0);

    // R9 data forwarding in receiving
    sel = 2'd3;
    bits = 4'd1;
    wait_state(2);
    data = ~data;
    repeat (half_of(3)) @(negedge clk);
    data = ~data;
    repeat (3) @(negedge clk);
    check(state == 2'd3, "R6 single interval qualifies", int'(state), 3);
    check(active == 1'b1, "R2 active in receiving", int'(active), 1);
    for (int i = 0; i < 16; i++) begin
      v = int'($urandom % 2);
      data = v[0];
      @(negedge clk);
      check(int'(dout) == v, "R9 data forwarded", int'(dout), v);
    end

    // R3 sleep length, word 3 ext 2
    word = 5'd3;
    ext  = 3'd2;
    off_pulse();
    count_run(0, n);
    check(n == exp_sleep(3, 2), "R3 sleep length 3x2", n, exp_sleep(3, 2));
    check(active == 1'b1, "R2 active after sleep", int'(active), 1);
    count_run(1, n);
    check(n == SU, "R4 start-up length again", n, SU);

    // R8 edge-free bit-check length, then R3 with ext 0
    word = 5'd1;
    ext  = 3'd0;
    sel  = 2'd3;
    count_run(2, n);
    check(n == lmax(3), "R8 timeout length range 3", n, lmax(3));
    check(state == 2'd0, "R8 timeout to sleep", int'(state), 0);
    count_run(0, n);
    check(n == exp_sleep(1, 0), "R3 ext zero as one", n, exp_sleep(1, 0));
    count_run(1, n);

    // R3 sleep word zero
    word = 5'd0;
    sel  = 2'd2;
    count_run(2, n);
    check(n == lmax(2), "R8 timeout length range 2", n, lmax(2));
    count_run(0, n);
    check(n == 1, "R3 zero word one cycle", n, 1);
    word = 5'd1;
    ext  = 3'd1;

    // R11 off ignored outside receiving
    wait_state(0);
    off = 1'b1;
    wait_state(1);
    wait_state(2);
    check(state == 2'd2, "R11 off ignored in sleep and start-up", int'(state), 2);
    off = 1'b0;

    // R7 short interval, R5 range dependence
    run_trial(3, 3, 1, lmin(3) - 1);
    run_trial(3, 2, 0, lmax(3) + 1);
    run_trial(0, 1, 0, half_of(3));
    run_trial(0, 2, -1, 0);
    run_trial(1, 0, -1, 0);

    // R5 R6 R7 randomised runs
    for (int t = 0; t < 40; t++) begin
      int r  = int'($urandom % 4);
      int nb = int'($urandom % 6);
      int ne = (nb == 0) ? 1 : nb;
      int ba = -1;
      int bl = 0;
      if ($urandom % 3 == 0) begin
        ba = int'($urandom % ne);
        bl = ($urandom % 2) ? lmin(r) - 1 : lmax(r) + 1;
      end
      run_trial(r, nb, ba, bl);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule